// File: doc/BRIEF.md
# Configuration Upset Classifier and Dispatcher

This block sits between a configuration-readback checker and the logic that repairs configuration memory. The checker writes 64-bit error event words into a small queue. The block takes the queued events one at a time and sorts each into one of five upset classes. For each event it issues either a scrub of the whole device, a scrub of one frame at the event's address, or no command at all.

A command stays outstanding from the cycle it is issued until the repair logic reports completion. While a command is outstanding, the block discards repeat reports of the upset being repaired and counts each discard. A new event that needs its own scrub waits at the head of the queue until the current repair has finished. Each classified event produces a one-cycle class pulse that can be observed.

Top module: `upset_dispatcher`

## Requirements
- R1: An event word uses this layout: bits [25:0] hold the frame address, [32:26] the syndrome word index, bit 33 the ECC-error flag, bit 34 the odd-count flag, bit 35 the CRC-error flag, [62:36] a checksum and bit 63 padding. The block ignores the checksum and padding bits. A write is accepted when `evt_full` is low and is ignored when `evt_full` is high. `evt_pending` is high while at least one event is queued.
- R2: An event whose frame address is zero gets class 0 and produces no command, whatever its flags are.
- R3: When the ECC-error flag is 0 and the CRC-error flag is 1, the event gets class 1 (unknown) and a whole-device scrub (`cmd_full`=1).
- R4: When the ECC-error flag is 1 and the odd-count flag is 0, the event gets class 2 (even-count multi-bit) and a single-frame scrub of its frame address (`cmd_full`=0).
- R5: When the ECC-error flag is 1, the odd-count flag is 1 and the word index is at least WORDS_PER_FRAME (default 101), the event gets class 3 (odd-count, out of bounds) and a single-frame scrub.
- R6: When the ECC-error flag is 1, the odd-count flag is 1 and the word index is in bounds, the CRC-error flag decides the result. With CRC-error 1 the event gets class 4 and a single-frame scrub. With CRC-error 0 it gets class 5 (single-bit, already corrected) and no command.
- R7: An event with a nonzero frame address and both the ECC-error and CRC-error flags at 0 gets class 0 and produces no command.
- R8: `cmd_valid`, `cmd_full` and `cmd_frame` hold steady until a cycle in which `cmd_ready` is high.
- R9: A command stays outstanding until a `scrub_done` pulse arrives after the handshake. A `scrub_done` pulse that arrives before the handshake is ignored. While a command is outstanding, the block drops without classifying any event with the same frame address, and any event at all if the outstanding command is a whole-device scrub. Each drop increments `dup_count`, which saturates at its maximum value.
- R10: While a command is outstanding, an event that needs a different scrub waits at the head of the queue. It is classified in the cycle after the completion.
- R11: An event written at one clock edge is classified at the next edge. `class_valid` is high for one cycle per classified event. Reset empties the queue, withdraws any command and clears `dup_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event write strobe |
| evt_word | input | 64 | Error event word |
| evt_full | output | 1 | Queue full; writes are ignored |
| evt_pending | output | 1 | Queue holds at least one event |
| cmd_valid | output | 1 | Scrub command offered |
| cmd_ready | input | 1 | Repair logic takes the command |
| cmd_full | output | 1 | 1 = whole-device scrub, 0 = single frame |
| cmd_frame | output | 26 | Frame address for a single-frame scrub |
| scrub_done | input | 1 | Completion pulse for the outstanding command |
| class_valid | output | 1 | One-cycle class pulse |
| class_code | output | 3 | Upset class of the event just classified |
| dup_count | output | DUP_W | Saturating count of dropped duplicate events |

## Verification
The assertions assume the repair logic pulses `scrub_done` only after it has taken a command. They also assume the producer does not care about writes made while `evt_full` is high. The bench keeps within these assumptions: it raises `cmd_ready` only while a command is offered, and it sends completion after the handshake. The one exception is a single early completion pulse, which is there to show that such a pulse is ignored. Every event in the table is repaired before the next one is written, so no entry in the table is treated as a repeat. The bench sets up duplicates, stalls and queue overflow only in the directed tests.

// File: rtl/upset_pkg.sv
package upset_pkg;

   typedef enum logic [2:0] {
      CLS_NONE      = 3'd0,
      CLS_UNKNOWN   = 3'd1,
      CLS_EVEN_MBU  = 3'd2,
      CLS_ODD_OOB   = 3'd3,
      CLS_ODD_INB   = 3'd4,
      CLS_SBU_FIXED = 3'd5
   } upset_cls_e;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_FRAME = 2'd1,
      ACT_FULL  = 2'd2
   } scrub_act_e;

endpackage

// File: rtl/evq_fifo.sv
module evq_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         not_empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("evq_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          wr_go, rd_go;

   assign full      = (cnt == CW'(DEPTH));
   assign not_empty = (cnt != '0);
   assign wr_go     = wr_en && !full;
   assign rd_go     = rd_en && not_empty;
   assign rd_data   = mem[rp];

   generate
      if (POW2) begin : g_wrap_native
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_go) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_go) wp <= wp_nx;
         if (rd_go) rp <= rp_nx;
         case ({wr_go, rd_go})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(DEPTH));

   assert_full_write_ignored_R1: assert property (@(posedge clk) disable iff (rst)
      (full && !rd_en) |=> full && $stable(wp));

endmodule

// File: rtl/upset_sorter.sv
module upset_sorter
   import upset_pkg::*;
#(
   parameter int FA_W            = 26,
   parameter int WI_W            = 7,
   parameter int WORDS_PER_FRAME = 101
) (
   input  logic [FA_W-1:0] frame,
   input  logic [WI_W-1:0] widx,
   input  logic            ecc_err,
   input  logic            odd_cnt,
   input  logic            crc_err,
   output upset_cls_e      cls,
   output scrub_act_e      act
);
   generate
      if (WORDS_PER_FRAME < 1 || WORDS_PER_FRAME > (1 << WI_W)) begin : g_bad_words
         $error("upset_sorter: WORDS_PER_FRAME does not fit the word index");
      end
   endgenerate

   logic in_bounds;
   assign in_bounds = ({1'b0, widx} < (WI_W + 1)'(WORDS_PER_FRAME));

   always_comb begin
      cls = CLS_NONE;
      act = ACT_NONE;
      if (frame == '0) begin
         cls = CLS_NONE;
      end else if (!ecc_err) begin
         if (crc_err) begin
            cls = CLS_UNKNOWN;
            act = ACT_FULL;
         end
      end else if (!odd_cnt) begin
         cls = CLS_EVEN_MBU;
         act = ACT_FRAME;
      end else if (!in_bounds) begin
         cls = CLS_ODD_OOB;
         act = ACT_FRAME;
      end else if (crc_err) begin
         cls = CLS_ODD_INB;
         act = ACT_FRAME;
      end else begin
         cls = CLS_SBU_FIXED;
      end
   end

endmodule

// File: rtl/scrub_tracker.sv
module scrub_tracker #(
   parameter int FA_W  = 26,
   parameter int DUP_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            issue,
   input  logic            issue_full,
   input  logic [FA_W-1:0] issue_frame,
   input  logic            cmd_ready,
   input  logic            scrub_done,
   input  logic            dup_hit,
   output logic            cmd_valid,
   output logic            cmd_full,
   output logic [FA_W-1:0] cmd_frame,
   output logic            busy,
   output logic [DUP_W-1:0] dup_count
);
   generate
      if (DUP_W < 1) begin : g_bad_dup
         $error("scrub_tracker: DUP_W must be at least 1");
      end
   endgenerate

   localparam logic [DUP_W-1:0] DUP_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_valid <= 1'b0;
         cmd_full  <= 1'b0;
         cmd_frame <= '0;
         busy      <= 1'b0;
      end else if (issue) begin
         cmd_valid <= 1'b1;
         cmd_full  <= issue_full;
         cmd_frame <= issue_frame;
         busy      <= 1'b1;
      end else begin
         if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
         if (busy && !cmd_valid && scrub_done) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                              dup_count <= '0;
      else if (dup_hit && dup_count != DUP_MAX) dup_count <= dup_count + 1'b1;
   end

   assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_frame) && $stable(cmd_full));

   assert_dup_monotonic_R9: assert property (@(posedge clk) disable iff (rst)
      (dup_count != '0) |=> dup_count >= $past(dup_count));

   assert_no_issue_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
      issue |-> !busy);

   assert_no_drop_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
      dup_hit |-> busy);

endmodule

// File: rtl/upset_dispatcher.sv
module upset_dispatcher
   import upset_pkg::*;
#(
   parameter int EVT_W           = 64,
   parameter int FA_W            = 26,
   parameter int WI_W            = 7,
   parameter int WORDS_PER_FRAME = 101,
   parameter int Q_DEPTH         = 4,
   parameter int DUP_W           = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             evt_valid,
   input  logic [EVT_W-1:0] evt_word,
   output logic             evt_full,
   output logic             evt_pending,
   output logic             cmd_valid,
   input  logic             cmd_ready,
   output logic             cmd_full,
   output logic [FA_W-1:0]  cmd_frame,
   input  logic             scrub_done,
   output logic             class_valid,
   output logic [2:0]       class_code,
   output logic [DUP_W-1:0] dup_count
);
   localparam int WI_LO   = FA_W;
   localparam int FLG_LO  = FA_W + WI_W;
   localparam int USED_W  = FLG_LO + 3;

   generate
      if (USED_W + 1 > EVT_W) begin : g_bad_layout
         $error("upset_dispatcher: fields do not fit the event word");
      end
   endgenerate

   logic [EVT_W-1:0] head;
   logic             head_ok;
   logic [FA_W-1:0]  h_frame;
   logic [WI_W-1:0]  h_widx;
   logic             h_ecc, h_odd, h_crc;
   logic             unused_tail;
   upset_cls_e       cls;
   scrub_act_e       act;
   logic             busy, is_dup, needs, stall, pop, classify, issue;

   evq_fifo #(.W(EVT_W), .DEPTH(Q_DEPTH)) u_q (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (evt_valid),
      .wr_data   (evt_word),
      .rd_en     (pop),
      .rd_data   (head),
      .not_empty (head_ok),
      .full      (evt_full)
   );

   assign evt_pending = head_ok;
   assign h_frame     = head[FA_W-1:0];
   assign h_widx      = head[WI_LO +: WI_W];
   assign h_ecc       = head[FLG_LO];
   assign h_odd       = head[FLG_LO+1];
   assign h_crc       = head[FLG_LO+2];
   assign unused_tail = ^head[EVT_W-1:USED_W];

   upset_sorter #(.FA_W(FA_W), .WI_W(WI_W), .WORDS_PER_FRAME(WORDS_PER_FRAME)) u_sort (
      .frame   (h_frame),
      .widx    (h_widx),
      .ecc_err (h_ecc),
      .odd_cnt (h_odd),
      .crc_err (h_crc),
      .cls     (cls),
      .act     (act)
   );

   assign is_dup   = busy && (cmd_full || h_frame == cmd_frame);
   assign needs    = (act != ACT_NONE);
   assign stall    = busy && !is_dup && needs;
   assign pop      = head_ok && !stall;
   assign classify = head_ok && !is_dup && !stall;
   assign issue    = classify && needs;

   scrub_tracker #(.FA_W(FA_W), .DUP_W(DUP_W)) u_trk (
      .clk         (clk),
      .rst         (rst),
      .issue       (issue),
      .issue_full  (act == ACT_FULL),
      .issue_frame (h_frame),
      .cmd_ready   (cmd_ready),
      .scrub_done  (scrub_done),
      .dup_hit     (head_ok && is_dup),
      .cmd_valid   (cmd_valid),
      .cmd_full    (cmd_full),
      .cmd_frame   (cmd_frame),
      .busy        (busy),
      .dup_count   (dup_count)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         class_valid <= 1'b0;
         class_code  <= 3'd0;
      end else begin
         class_valid <= classify;
         class_code  <= classify ? 3'(cls) : 3'd0;
      end
   end

   assert_class_range_R11: assert property (@(posedge clk) disable iff (rst)
      class_valid |-> class_code <= 3'd5);

   assert_cmd_with_class_R11: assert property (@(posedge clk) disable iff (rst)
      $rose(cmd_valid) |-> class_valid);

   assert_sbu_no_cmd_R6: assert property (@(posedge clk) disable iff (rst)
      (class_valid && class_code == 3'd5) |-> !$rose(cmd_valid));

   assert_zero_frame_no_cmd_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(cmd_valid) && !cmd_full |-> cmd_frame != '0);

endmodule

// File: tb/tb_upset_dispatcher.sv
`timescale 1ns/1ps
module tb_upset_dispatcher;
   localparam int FA_W = 26;
   localparam int DW   = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic evt_valid = 1'b0;
   logic [63:0] evt_word = '0;
   logic evt_full, evt_pending, cmd_valid, cmd_full, class_valid;
   logic cmd_ready = 1'b0;
   logic scrub_done = 1'b0;
   logic [FA_W-1:0] cmd_frame;
   logic [2:0] class_code;
   logic [DW-1:0] dup_count;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   upset_dispatcher #(.DUP_W(DW)) dut (
      .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_word(evt_word),
      .evt_full(evt_full), .evt_pending(evt_pending), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_full(cmd_full), .cmd_frame(cmd_frame),
      .scrub_done(scrub_done), .class_valid(class_valid), .class_code(class_code),
      .dup_count(dup_count)
   );

   // frame(26) widx(7) ecc odd crc exp_class(3) exp_cmd(2: 0 none, 1 frame, 2 full)
   localparam int NV = 11;
   localparam logic [40:0] VEC [NV] = '{
      {26'h0000000, 7'd5,   1'b1, 1'b0, 1'b1, 3'd0, 2'd0},  // R2 zero frame
      {26'h0000010, 7'd3,   1'b0, 1'b0, 1'b1, 3'd1, 2'd2},  // R3 unknown
      {26'h0000020, 7'd9,   1'b1, 1'b0, 1'b1, 3'd2, 2'd1},  // R4 even
      {26'h0000030, 7'd101, 1'b1, 1'b1, 1'b0, 3'd3, 2'd1},  // R5 boundary
      {26'h0000031, 7'd127, 1'b1, 1'b1, 1'b1, 3'd3, 2'd1},  // R5 top index
      {26'h0000040, 7'd100, 1'b1, 1'b1, 1'b1, 3'd4, 2'd1},  // R6 last in-bounds
      {26'h0000041, 7'd0,   1'b1, 1'b1, 1'b0, 3'd5, 2'd0},  // R6 corrected
      {26'h0000050, 7'd2,   1'b0, 1'b0, 1'b0, 3'd0, 2'd0},  // R7 no flags
      {26'h3FFFFFF, 7'd1,   1'b1, 1'b0, 1'b0, 3'd2, 2'd1},  // R4 max frame
      {26'h0000000, 7'd1,   1'b0, 1'b0, 1'b1, 3'd0, 2'd0},  // R2 zero beats crc
      {26'h0000060, 7'd50,  1'b0, 1'b1, 1'b1, 3'd1, 2'd2}   // R3 odd flag ignored
   };

   function automatic logic [63:0] mkw(logic [25:0] fr, logic [6:0] wi,
                                       logic e, logic o, logic c);
      return {1'b1, 27'h5A5A5A5, c, o, e, wi, fr};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(logic [63:0] w);
      evt_valid = 1'b1;
      evt_word  = w;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic accept();
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   task automatic finish_scrub();
      scrub_done = 1'b1;
      @(negedge clk);
      scrub_done = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11 / R1 reset state
      check("R11 reset cmd_valid", 32'(cmd_valid), 0);
      check("R11 reset class_valid", 32'(class_valid), 0);
      check("R1 reset evt_pending", 32'(evt_pending), 0);
      check("R1 reset evt_full", 32'(evt_full), 0);
      check("R11 reset dup_count", 32'(dup_count), 0);

      for (int i = 0; i < NV; i++) begin
         logic [40:0] v;
         v = VEC[i];
         push(mkw(v[40:15], v[14:8], v[7], v[6], v[5]));
         @(negedge clk);
         check("R11 class pulse", 32'(class_valid), 1);
         check("R2-R7 class code", 32'(class_code), 32'(v[4:2]));
         check("R3-R6 cmd_valid", 32'(cmd_valid), 32'(v[1:0] != 2'd0));
         if (v[1:0] != 2'd0) begin
            check("R3 R4 cmd_full", 32'(cmd_full), 32'(v[1:0] == 2'd2));
            if (v[1:0] == 2'd1) check("R4 R5 cmd_frame", 32'(cmd_frame), 32'(v[40:15]));
            accept();
            check("R8 cmd released", 32'(cmd_valid), 0);
            finish_scrub();
         end else begin
            @(negedge clk);
            check("R11 one-cycle pulse", 32'(class_valid), 0);
         end
      end
      check("R9 no drops in table", 32'(dup_count), 0);

      // R8 hold, R9 duplicate, R10 stall
      push(mkw(26'h123, 7'd4, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      repeat (3) @(negedge clk);
      check("R8 held valid", 32'(cmd_valid), 1);
      check("R8 held frame", 32'(cmd_frame), 32'h123);
      push(mkw(26'h123, 7'd7, 1'b1, 1'b1, 1'b1));
      @(negedge clk);
      check("R9 dup not classified", 32'(class_valid), 0);
      check("R9 dup counted", 32'(dup_count), 1);
      check("R9 dup removed", 32'(evt_pending), 0);
      push(mkw(26'h200, 7'd4, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      check("R10 stall no class", 32'(class_valid), 0);
      check("R10 stall held", 32'(evt_pending), 1);
      finish_scrub();                    // before handshake: ignored
      @(negedge clk);
      check("R9 early done ignored", 32'(evt_pending), 1);
      check("R9 early done cmd", 32'(cmd_frame), 32'h123);
      accept();
      @(negedge clk);
      check("R10 still stalled after accept", 32'(evt_pending), 1);
      finish_scrub();
      @(negedge clk);
      check("R10 released class", 32'(class_code), 2);
      check("R10 released valid", 32'(class_valid), 1);
      check("R10 new frame", 32'(cmd_frame), 32'h200);
      accept();
      finish_scrub();

      // R9 full-device pending drops everything
      push(mkw(26'h77, 7'd0, 1'b0, 1'b0, 1'b1));
      @(negedge clk);
      check("R3 full issued", 32'(cmd_full), 1);
      accept();
      push(mkw(26'h0, 7'd0, 1'b0, 1'b0, 1'b0));
      @(negedge clk);
      check("R9 full drop zero", 32'(dup_count), 2);
      push(mkw(26'h999, 7'd0, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      check("R9 full drop other", 32'(dup_count), 3);
      check("R9 full drop no class", 32'(class_valid), 0);
      finish_scrub();
      push(mkw(26'h999, 7'd0, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      check("R9 after done classified", 32'(class_valid), 1);
      accept();
      finish_scrub();

      // R9 saturation (DUP_W=3 -> 7)
      push(mkw(26'h55, 7'd0, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      for (int k = 0; k < 5; k++) begin
         push(mkw(26'h55, 7'd1, 1'b1, 1'b1, 1'b1));
         @(negedge clk);
      end
      check("R9 saturate", 32'(dup_count), 7);
      accept();
      finish_scrub();

      // R1 queue full, write ignored
      push(mkw(26'h66, 7'd0, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      for (int k = 0; k < 4; k++) push(mkw(26'h300, 7'd0, 1'b1, 1'b0, 1'b0));
      check("R1 full flag", 32'(evt_full), 1);
      push(mkw(26'h400, 7'd0, 1'b1, 1'b0, 1'b0));
      accept();
      finish_scrub();
      repeat (5) @(negedge clk);
      check("R1 extra write ignored", 32'(evt_pending), 0);
      check("R1 drained frame", 32'(cmd_frame), 32'h300);
      accept();
      finish_scrub();

      // R11 reset mid-flight
      push(mkw(26'h500, 7'd0, 1'b1, 1'b0, 1'b0));
      push(mkw(26'h600, 7'd0, 1'b1, 1'b0, 1'b0));
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11 reset cmd", 32'(cmd_valid), 0);
      check("R11 reset queue", 32'(evt_pending), 0);
      check("R11 reset dup", 32'(dup_count), 0);
      check("R11 reset class", 32'(class_valid), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule